// File: doc/BRIEF.md
# Wired Interrupt Pending-State Controller

This block keeps the pending flag for each of a set of wired interrupt lines inside an interrupt controller that can hand interrupts on as messages. Every source has a three-bit trigger mode: off, rising edge, falling edge, active-high level or active-low level. The raw lines pass through a two-flop synchroniser, and the pending flags are updated from the synchronised lines, from software writes of a source number, and from a forward acknowledge. A single input chooses between direct delivery and message delivery, and that choice changes how level sources respond to software.

Software uses one 32-bit write port. It writes a source number to set or clear that source's pending flag, or to enable or disable it, and it writes a mode value to a per-source configuration word. The block presents the lowest-numbered source that is both pending and enabled. Whatever turns that source into a message acknowledges it with a one-cycle strobe that carries the number, and that strobe clears the flag. The candidate output is a plain level, so there is no back-pressure. The acknowledge is a plain strobe with no ready signal, and the block accepts it in the cycle it appears.

Top module: `irq_pend_ctrl`

## Requirements
- R1: A synchronous active-high reset clears all pending flags, all enables and the synchroniser, and sets every mode to off. After reset, `pending_o` is 0, `top_valid` is 0 and `top_id` is 0.
- R2: Mode codes are 0 = off, 4 = rising edge, 5 = falling edge, 6 = active-high level and 7 = active-low level. Codes 1 to 3 also mean off. An off source always reads pending 0, and no set request changes that.
- R3: An edge source sets its pending flag on its configured edge of the synchronised line. The flag shows on the third rising clock edge after the line changes.
- R4: For edge sources, software set and clear requests always take effect at the next clock edge. A detected edge wins over a clear or an acknowledge that arrives in the same cycle.
- R5: With `msg_mode`=0 (direct delivery), a level source's pending flag follows its synchronised line, inverted for active-low. Software set and clear requests and acknowledges have no effect on it.
- R6: With `msg_mode`=1 (message delivery), a level source's pending flag sets when its synchronised line becomes asserted and clears on an acknowledge. A software clear request for it has no effect.
- R7: With `msg_mode`=1, a software set request for a level source takes effect only while the synchronised line is asserted at the source's polarity: high for mode 6, low for mode 7.
- R8: A software set, clear, enable or disable write whose data is 0 or greater than NSRC has no effect.
- R9: A write to address 2 enables the named source, and a write to address 3 disables it. Only enabled sources can appear on `top_id`.
- R10: Writes with `wr_en`=1 go to these word addresses: 0 = set pending, 1 = clear pending, 2 = enable, 3 = disable, and 32+n = mode of source n taken from `wr_data[2:0]` (n from 1 to NSRC). All other addresses, including 32, are ignored. Every write takes effect at the next clock edge.
- R11: `top_valid` is 1 when at least one source is both pending and enabled, and `top_id` then gives the lowest such number. When no source qualifies, `top_id` is 0.
- R12: An acknowledge (`ack_valid`=1 with `ack_id`=n) clears source n's pending flag at the next edge when n is an edge source (either delivery mode) or a level source in message delivery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| msg_mode | input | 1 | 1 = message delivery, 0 = direct delivery |
| irq_in | input | NSRC | Raw interrupt lines, bit n is source n |
| wr_en | input | 1 | Register write strobe, one cycle |
| wr_addr | input | AW | Register word address |
| wr_data | input | DW | Write data (source number or mode) |
| ack_valid | input | 1 | Forward acknowledge strobe |
| ack_id | input | IDW | Number of the forwarded source |
| pending_o | output | NSRC | Pending flags, bit n is source n |
| top_valid | output | 1 | Some source is pending and enabled |
| top_id | output | IDW | Lowest pending and enabled source, 0 if none |

## Verification
On every cycle, the assertions check that a set request on an edge source always lands, that a clear request on a pending level source in message delivery never removes its flag, and that the presented candidate is pending, enabled and the lowest such source. The polarity gate on software set requests, the three-edge input latency, the direct-mode mirroring of the line and the ignoring of reserved numbers and addresses all depend on the synchroniser history. Only the bench scenarios and its per-cycle reference model show those.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;
  // source trigger mode codes; bit 2 set means the source is active
  localparam logic [2:0] SM_OFF  = 3'd0;
  localparam logic [2:0] SM_RISE = 3'd4;
  localparam logic [2:0] SM_FALL = 3'd5;
  localparam logic [2:0] SM_HIGH = 3'd6;
  localparam logic [2:0] SM_LOW  = 3'd7;

  // register word addresses
  localparam int ADR_SET = 0;
  localparam int ADR_CLR = 1;
  localparam int ADR_EN  = 2;
  localparam int ADR_DIS = 3;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int N = 31
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N:1]   line_i,
  output logic [N:1]   cur_o,
  output logic [N:1]   prv_o
);
  logic [N:1] st1_q, st2_q, st3_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st1_q <= '0;
      st2_q <= '0;
      st3_q <= '0;
    end else begin
      st1_q <= line_i;
      st2_q <= st1_q;
      st3_q <= st2_q;
    end
  end

  assign cur_o = st2_q;
  assign prv_o = st3_q;
endmodule

// File: rtl/irq_src_cell.sv
module irq_src_cell
  import irq_pend_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       msg_mode,
  input  logic       cur,
  input  logic       prv,
  input  logic       sw_set,
  input  logic       sw_clr,
  input  logic       en_set,
  input  logic       en_clr,
  input  logic       ack_hit,
  input  logic       cfg_we,
  input  logic [2:0] cfg_val,
  output logic       pend_o,
  output logic       en_o,
  output logic [2:0] mode_o
);
  logic [2:0] mode_q;
  logic       pend_q, en_q, pend_nx;
  logic       rect_cur, rect_prv;

  always_comb begin
    rect_cur = (mode_q == SM_LOW) ? ~cur : cur;
    rect_prv = (mode_q == SM_LOW) ? ~prv : prv;
    case (mode_q)
      SM_RISE: pend_nx = (pend_q & ~sw_clr & ~ack_hit) | sw_set | (cur & ~prv);
      SM_FALL: pend_nx = (pend_q & ~sw_clr & ~ack_hit) | sw_set | (~cur & prv);
      SM_HIGH, SM_LOW: begin
        if (!msg_mode) pend_nx = rect_cur;
        else pend_nx = (pend_q & ~ack_hit) | (rect_cur & ~rect_prv) | (sw_set & rect_cur);
      end
      default: pend_nx = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= SM_OFF;
      pend_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      pend_q <= pend_nx;
      if (cfg_we) mode_q <= cfg_val;
      if (en_set) en_q <= 1'b1;
      else if (en_clr) en_q <= 1'b0;
    end
  end

  assign pend_o = pend_q & mode_q[2];
  assign en_o   = en_q;
  assign mode_o = mode_q;
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N   = 31,
  parameter int IDW = 5
) (
  input  logic [N:1]     req_i,
  output logic           valid_o,
  output logic [IDW-1:0] id_o
);
  always_comb begin
    id_o = '0;
    for (int i = N; i >= 1; i--) begin
      if (req_i[i]) id_o = IDW'(i);
    end
  end

  assign valid_o = |req_i;
endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
  import irq_pend_pkg::*;
#(
  parameter int NSRC = 31,
  parameter int DW   = 32,
  parameter int AW   = 6,
  localparam int IDW = $clog2(NSRC + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            msg_mode,
  input  logic [NSRC:1]   irq_in,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic            ack_valid,
  input  logic [IDW-1:0]  ack_id,
  output logic [NSRC:1]   pending_o,
  output logic            top_valid,
  output logic [IDW-1:0]  top_id
);
  localparam int CFG_BASE = 2 ** (AW - 1);

  logic [NSRC:1]      cur_s, prv_s;
  logic [NSRC:1]      en_q;
  logic [NSRC:1][2:0] mode_q;
  logic wr_set, wr_clr, wr_ena, wr_dis;

  assign wr_set = wr_en && (wr_addr == AW'(ADR_SET));
  assign wr_clr = wr_en && (wr_addr == AW'(ADR_CLR));
  assign wr_ena = wr_en && (wr_addr == AW'(ADR_EN));
  assign wr_dis = wr_en && (wr_addr == AW'(ADR_DIS));

  irq_sync #(.N(NSRC)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .line_i (irq_in),
    .cur_o  (cur_s),
    .prv_o  (prv_s)
  );

  for (genvar g = 1; g <= NSRC; g++) begin : g_src
    logic num_hit;
    assign num_hit = (wr_data == DW'(g));

    irq_src_cell u_cell (
      .clk      (clk),
      .rst      (rst),
      .msg_mode (msg_mode),
      .cur      (cur_s[g]),
      .prv      (prv_s[g]),
      .sw_set   (wr_set && num_hit),
      .sw_clr   (wr_clr && num_hit),
      .en_set   (wr_ena && num_hit),
      .en_clr   (wr_dis && num_hit),
      .ack_hit  (ack_valid && (ack_id == IDW'(g))),
      .cfg_we   (wr_en && (wr_addr == AW'(CFG_BASE + g))),
      .cfg_val  (wr_data[2:0]),
      .pend_o   (pending_o[g]),
      .en_o     (en_q[g]),
      .mode_o   (mode_q[g])
    );
  end

  irq_pick #(.N(NSRC), .IDW(IDW)) u_pick (
    .req_i   (pending_o & en_q),
    .valid_o (top_valid),
    .id_o    (top_id)
  );
endmodule

// File: rtl/irq_pend_chk.sv
module irq_pend_chk #(
  parameter int NSRC = 31,
  parameter int DW   = 32,
  parameter int AW   = 6,
  localparam int IDW = $clog2(NSRC + 1)
) (
  input logic               clk,
  input logic               rst,
  input logic               msg_mode,
  input logic               wr_en,
  input logic [AW-1:0]      wr_addr,
  input logic [DW-1:0]      wr_data,
  input logic               ack_valid,
  input logic [IDW-1:0]     ack_id,
  input logic [NSRC:1]      pending_o,
  input logic               top_valid,
  input logic [IDW-1:0]     top_id,
  input logic [NSRC:1][2:0] mode_q,
  input logic [NSRC:1]      en_q
);
  logic [NSRC:1] req, below;

  always_comb begin
    req = pending_o & en_q;
    for (int i = 1; i <= NSRC; i++) below[i] = (IDW'(i) < top_id);
  end

  // R11
  top_hit_chk: assert property (@(posedge clk) disable iff (rst)
    top_valid |-> (pending_o[top_id] && en_q[top_id]));

  // R11
  top_low_chk: assert property (@(posedge clk) disable iff (rst)
    top_valid |-> ((req & below) == '0));

  // R11
  top_none_chk: assert property (@(posedge clk) disable iff (rst)
    !top_valid |-> (req == '0 && top_id == '0));

  for (genvar g = 1; g <= NSRC; g++) begin : g_chk
    // R4
    edge_set_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_addr == AW'(0) && wr_data == DW'(g) && mode_q[g][2:1] == 2'b10)
      |=> pending_o[g]);

    // R6
    lvl_clr_ign_chk: assert property (@(posedge clk) disable iff (rst)
      (msg_mode && mode_q[g][2:1] == 2'b11 && pending_o[g] &&
       wr_en && wr_addr == AW'(1) && wr_data == DW'(g) &&
       !(ack_valid && ack_id == IDW'(g)))
      |=> pending_o[g]);
  end
endmodule

bind irq_pend_ctrl irq_pend_chk #(.NSRC(NSRC), .DW(DW), .AW(AW)) u_chk (.*);

// File: tb/test_irq_pend_ctrl.sv
module test_irq_pend_ctrl;
  localparam int NSRC = 31;
  localparam int DW   = 32;
  localparam int AW   = 6;
  localparam int IDW  = 5;
  localparam int CLK_P = 10;

  logic            clk = 1'b0;
  logic            rst;
  logic            msg_mode;
  logic [NSRC:1]   irq_in;
  logic            wr_en;
  logic [AW-1:0]   wr_addr;
  logic [DW-1:0]   wr_data;
  logic            ack_valid;
  logic [IDW-1:0]  ack_id;
  logic [NSRC:1]   pending_o;
  logic            top_valid;
  logic [IDW-1:0]  top_id;

  always #(CLK_P / 2) clk = ~clk;

  irq_pend_ctrl #(.NSRC(NSRC), .DW(DW), .AW(AW)) i_irq_pend_ctrl (
    .clk(clk), .rst(rst), .msg_mode(msg_mode), .irq_in(irq_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ack_valid(ack_valid), .ack_id(ack_id),
    .pending_o(pending_o), .top_valid(top_valid), .top_id(top_id)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  int    cyc = 0;
  bit    done = 0;
  string tag = "R1";

  task automatic chk(input string r, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  // behavioural reference model
  bit [2:0] m_mode [NSRC+1];
  bit       m_pend [NSRC+1];
  bit       m_en   [NSRC+1];
  bit       m_a [NSRC+1];
  bit       m_b [NSRC+1];
  bit       m_c [NSRC+1];

  function automatic bit [NSRC:1] model_pend();
    bit [NSRC:1] v;
    for (int i = 1; i <= NSRC; i++) v[i] = m_pend[i] && (m_mode[i] >= 3'd4);
    return v;
  endfunction

  task automatic model_step();
    bit np [NSRC+1];
    for (int i = 1; i <= NSRC; i++) begin
      bit lo, now, old, s, c, k;
      lo  = (m_mode[i] == 3'd7);
      now = lo ? !m_b[i] : m_b[i];
      old = lo ? !m_c[i] : m_c[i];
      s = wr_en && wr_addr == 0 && wr_data == i;
      c = wr_en && wr_addr == 1 && wr_data == i;
      k = ack_valid && ack_id == i;
      if (m_mode[i] == 3'd4) np[i] = (m_pend[i] && !c && !k) || s || (m_b[i] && !m_c[i]);
      else if (m_mode[i] == 3'd5) np[i] = (m_pend[i] && !c && !k) || s || (!m_b[i] && m_c[i]);
      else if (m_mode[i] >= 3'd6) begin
        if (!msg_mode) np[i] = now;
        else np[i] = (m_pend[i] && !k) || (now && !old) || (s && now);
      end else np[i] = 0;
    end
    for (int i = 1; i <= NSRC; i++) begin
      m_pend[i] = np[i];
      if (wr_en && wr_addr == 2 && wr_data == i) m_en[i] = 1;
      if (wr_en && wr_addr == 3 && wr_data == i) m_en[i] = 0;
      if (wr_en && wr_addr == 32 + i) m_mode[i] = wr_data[2:0];
      m_c[i] = m_b[i];
      m_b[i] = m_a[i];
      m_a[i] = irq_in[i];
    end
  endtask

  always @(posedge clk) begin
    bit [NSRC:1] ev;
    int et;
    if (rst) begin
      for (int i = 0; i <= NSRC; i++) begin
        m_mode[i] = 0; m_pend[i] = 0; m_en[i] = 0;
        m_a[i] = 0; m_b[i] = 0; m_c[i] = 0;
      end
    end else begin
      model_step();
    end
    #(CLK_P / 4);
    ev = model_pend();
    et = 0;
    for (int i = NSRC; i >= 1; i--) if (ev[i] && m_en[i]) et = i;
    if (!done) begin
      chk(tag, "pending per cycle", 64'(pending_o), 64'(ev));
      chk(tag, "top_valid per cycle", 64'(top_valid), 64'(et != 0));
      chk(tag, "top_id per cycle", 64'(top_id), 64'(et));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic wr(input int a, input int d);
    wr_en = 1; wr_addr = AW'(a); wr_data = DW'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic ack(input int id);
    ack_valid = 1; ack_id = IDW'(id);
    @(negedge clk);
    ack_valid = 0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    bit [NSRC:1] snap;
    rst = 1; msg_mode = 0; irq_in = '0; wr_en = 0; wr_addr = '0; wr_data = '0;
    ack_valid = 0; ack_id = '0;
    wait_n(3);
    rst = 0;
    wait_n(1);
    // R1 reset state
    chk("R1", "pending after reset", 64'(pending_o), 0);
    chk("R1", "top_valid after reset", 64'(top_valid), 0);
    chk("R1", "top_id after reset", 64'(top_id), 0);

    // R3 rising edge with latency
    tag = "R3";
    wr(32 + 3, 4); wr(2, 3);
    irq_in[3] = 1;
    wait_n(2);
    chk("R3", "rise not yet visible", 64'(pending_o[3]), 0);
    wait_n(1);
    chk("R3", "rise visible third edge", 64'(pending_o[3]), 1);
    chk("R11", "top is source 3", 64'(top_id), 3);

    // R12 acknowledge clears
    tag = "R12";
    ack(3);
    chk("R12", "ack clears edge source", 64'(pending_o[3]), 0);

    // R4 software set and clear on edge source
    tag = "R4";
    wr(0, 3);
    chk("R4", "sw set edge", 64'(pending_o[3]), 1);
    wr(1, 3);
    chk("R4", "sw clear edge", 64'(pending_o[3]), 0);

    // R3 falling edge
    tag = "R3";
    wr(32 + 5, 5);
    irq_in[5] = 1;
    wait_n(4);
    chk("R3", "falling source ignores rise", 64'(pending_o[5]), 0);
    irq_in[5] = 0;
    wait_n(3);
    chk("R3", "falling edge sets", 64'(pending_o[5]), 1);
    ack(5);

    // R2 inactive and reserved modes
    tag = "R2";
    wr(32 + 7, 0); wr(0, 7);
    chk("R2", "off source set ignored", 64'(pending_o[7]), 0);
    wr(32 + 7, 2); wr(0, 7);
    chk("R2", "reserved mode set ignored", 64'(pending_o[7]), 0);

    // R8 reserved numbers
    tag = "R8";
    wr(32 + 8, 4);
    wr(0, 0); wr(0, 32);
    chk("R8", "numbers 0 and 32 ignored", 64'(pending_o), 0);

    // R5 direct delivery level source
    tag = "R5";
    wr(32 + 9, 6); wr(2, 9);
    irq_in[9] = 1;
    wait_n(3);
    chk("R5", "direct level mirrors line", 64'(pending_o[9]), 1);
    wr(1, 9);
    chk("R5", "direct sw clear ignored", 64'(pending_o[9]), 1);
    ack(9);
    chk("R5", "direct ack ignored", 64'(pending_o[9]), 1);
    irq_in[9] = 0;
    wait_n(3);
    chk("R5", "direct level follows drop", 64'(pending_o[9]), 0);
    wr(0, 9);
    chk("R5", "direct sw set ignored", 64'(pending_o[9]), 0);

    // R6 / R7 message delivery level-high
    msg_mode = 1;
    tag = "R6";
    wr(32 + 10, 6); wr(2, 10);
    irq_in[10] = 1;
    wait_n(3);
    chk("R6", "assertion sets pending", 64'(pending_o[10]), 1);
    ack(10);
    chk("R6", "ack clears level", 64'(pending_o[10]), 0);
    tag = "R7";
    wr(0, 10);
    chk("R7", "re-arm while asserted", 64'(pending_o[10]), 1);
    wr(1, 10);
    chk("R6", "msg sw clear ignored", 64'(pending_o[10]), 1);
    ack(10);
    irq_in[10] = 0;
    wait_n(3);
    wr(0, 10);
    chk("R7", "set refused while deasserted", 64'(pending_o[10]), 0);

    // R7 / R6 level-low
    wr(32 + 11, 7);
    irq_in[11] = 1;
    wait_n(3);
    chk("R7", "low source idle", 64'(pending_o[11]), 0);
    wr(0, 11);
    chk("R7", "low source set refused while high", 64'(pending_o[11]), 0);
    tag = "R6";
    irq_in[11] = 0;
    wait_n(3);
    chk("R6", "low source asserts", 64'(pending_o[11]), 1);

    // R9 / R11 enable and lowest selection
    tag = "R9";
    wr(2, 11);
    wr(0, 3);
    chk("R11", "lowest of 3 and 11", 64'(top_id), 3);
    wr(3, 3);
    chk("R9", "disabled 3 skipped", 64'(top_id), 11);
    wr(3, 11);
    chk("R9", "none enabled", 64'(top_valid), 0);
    chk("R9", "pending kept when disabled", 64'(pending_o[11]), 1);

    // R10 unused addresses
    tag = "R10";
    snap = pending_o;
    wr(4, 11); wr(32, 0); wr(17, 3);
    chk("R10", "unused addresses ignored", 64'(pending_o), 64'(snap));
    wr(32 + 11, 0);
    chk("R2", "mode to off hides pending", 64'(pending_o[11]), 0);

    // random traffic against the model
    tag = "R10 random";
    for (int n = 0; n < 3000; n++) begin
      int r;
      if ($urandom % 8 == 0) begin
        int b;
        b = int'($urandom % NSRC) + 1;
        irq_in[b] = ~irq_in[b];
      end
      if ($urandom % 200 == 0) msg_mode = ~msg_mode;
      wr_en = ($urandom % 3 == 0);
      r = int'($urandom % 6);
      if (r < 4) begin
        wr_addr = AW'(r); wr_data = DW'($urandom % 34);
      end else if (r == 4) begin
        wr_addr = AW'(32 + ($urandom % 32)); wr_data = DW'($urandom % 8);
      end else begin
        wr_addr = AW'(5 + ($urandom % 27)); wr_data = DW'($urandom % 34);
      end
      ack_valid = ($urandom % 4 == 0);
      ack_id = top_valid && ($urandom % 2 == 0) ? top_id : IDW'($urandom % 32);
      @(negedge clk);
    end
    wr_en = 0; ack_valid = 0;
    wait_n(2);

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule